// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This controller converts single requests from an internal ready/valid port into read or write cycles on an external asynchronous memory bus. The bus suits SRAM or flash-style parts. Each cycle has three phases: setup, strobe and hold. Reads and writes each have their own three phase lengths, taken from configuration inputs. A turnaround gap closes every access. The bus carries four active-low chip selects, a 14-bit word address, a 2-bit byte-address field, and a 16-bit data bus split into output, input and output-enable. It also has active-low output-enable and write-enable strobes.

The strobe phase can be stretched by an external wait pin, with a programmable polarity. A programmable bound limits the stretch. When the bound expires, the cycle is forced to finish and a sticky timeout flag is set. A select-strobe mode narrows the chip select so that it is active only while the strobe is active. Read data is taken from the bus on the last strobe cycle and returned with a one-cycle valid pulse.

Configuration inputs must stay stable while an access is in progress.

Top module: `xmem_ctrl`

## Requirements
- R1: A read lasts cfg_rd_setup_i+1 setup cycles, then cfg_rd_strobe_i+1 strobe cycles with mem_oe_no low, then cfg_rd_hold_i+1 hold cycles. The first setup cycle is the cycle after the request is accepted. Every field is coded as its length minus one. mem_we_no stays high for the whole read.
- R2: A write uses cfg_wr_setup_i, cfg_wr_strobe_i and cfg_wr_hold_i in the same way, with mem_we_no low during the strobe and mem_oe_no held high. The read length fields have no effect on a write, and the write length fields have no effect on a read.
- R3: mem_addr_o and mem_ba_o hold the request's address and byte field from the first setup cycle through the last hold cycle. On a write, mem_dq_oe_o is high and mem_dq_o carries the write data over the same span. mem_dq_oe_o is low during reads, turnaround and idle.
- R4: req_cs_i (0 to 3) picks mem_cs_no[req_cs_i]; no other select goes low. When cfg_sel_strobe_i is 0, the select is low from the first setup cycle through the last hold cycle. When it is 1, the select is low only during the strobe cycles.
- R5: mem_wait_i is registered once and counts as asserted when it equals cfg_wait_pol_i (1 = active high). When cfg_wait_en_i is 1, the controller looks at the registered wait value on the last nominal strobe cycle. If it is asserted there, the strobe goes on until a strobe cycle sees the registered wait deasserted, and that cycle is the last strobe cycle. When cfg_wait_en_i is 0, the wait pin has no effect.
- R6: If the registered wait is still asserted in the (cfg_wait_max_i+1)-th extra strobe cycle, that cycle ends the strobe and err_timeout_o goes high. err_timeout_o stays high until err_clr_i is sampled high while no new timeout occurs.
- R7: On a read, mem_dq_i is captured on the last strobe cycle. rd_data_o then shows it while rd_valid_o is high for exactly one cycle, which is the first hold cycle.
- R8: After hold, cfg_turn_i+1 turnaround cycles follow. req_ready_o is high only when the controller is idle or in the last turnaround cycle. A request is accepted when req_valid_i and req_ready_o are both high.
- R9: After reset, all selects and strobes are high, mem_dq_oe_o, rd_valid_o and err_timeout_o are low, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | 2 | Chip select index |
| req_addr_i | input | 14 | Word address |
| req_ba_i | input | 2 | Byte-address field |
| req_wdata_i | input | 16 | Write data |
| cfg_turn_i | input | 2 | Turnaround length minus one |
| cfg_rd_setup_i | input | 4 | Read setup length minus one |
| cfg_rd_strobe_i | input | 6 | Read strobe length minus one |
| cfg_rd_hold_i | input | 3 | Read hold length minus one |
| cfg_wr_setup_i | input | 4 | Write setup length minus one |
| cfg_wr_strobe_i | input | 6 | Write strobe length minus one |
| cfg_wr_hold_i | input | 3 | Write hold length minus one |
| cfg_sel_strobe_i | input | 1 | Chip select follows the strobe |
| cfg_wait_en_i | input | 1 | Enable strobe extension by wait |
| cfg_wait_pol_i | input | 1 | Asserted level of mem_wait_i |
| cfg_wait_max_i | input | 8 | Maximum extra strobe cycles minus one |
| err_clr_i | input | 1 | Clear the timeout flag |
| err_timeout_o | output | 1 | Sticky wait timeout flag |
| rd_data_o | output | 16 | Captured read data |
| rd_valid_o | output | 1 | Read data valid pulse |
| mem_cs_no | output | 4 | Chip selects, active low |
| mem_addr_o | output | 14 | Bus address |
| mem_ba_o | output | 2 | Bus byte-address field |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_i | input | 16 | Data read from the bus |
| mem_dq_oe_o | output | 1 | Data output enable |
| mem_oe_no | output | 1 | Output-enable strobe, active low |
| mem_we_no | output | 1 | Write-enable strobe, active low |
| mem_wait_i | input | 1 | External wait |

## Verification
The assertions check the following on every cycle:
- At most one chip select is low.
- A strobe never occurs without a select, and the two strobes are never low together.
- The data bus is never driven during a read strobe.
- The address holds steady through a strobe.
- The read-valid pulse lasts one cycle and comes right after the output-enable strobe rises.
- The timeout flag stays set until it is cleared.
- No strobe occurs while the controller is ready.

Only the bench's scenarios can show the exact phase lengths, the separation between read and write fields, and the select-strobe window. The same holds for the number of extra strobe cycles added by a given wait waveform under either polarity, the forced end and flag at the timeout bound, and the turnaround length.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;
endpackage

// File: rtl/xmem_phase_ctr.sv
module xmem_phase_ctr #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xmem_wait_unit.sv
module xmem_wait_unit #(
  parameter int MW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wait_pin_i,
  input  logic            pol_i,
  input  logic            en_i,
  input  logic [MW_W-1:0] max_i,
  input  logic            strobe_i,
  input  logic            cnt_zero_i,
  input  logic            clr_i,
  output logic            last_o,
  output logic            timeout_o
);
  logic            wait_q;
  logic            ext_q;
  logic [MW_W-1:0] ewc_q;
  logic            at_max;

  assign at_max = (ewc_q == max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q    <= 1'b0;
      ext_q     <= 1'b0;
      ewc_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      wait_q <= (wait_pin_i == pol_i);
      if (!strobe_i) begin
        ext_q <= 1'b0;
      end else if (!ext_q) begin
        if (cnt_zero_i && en_i && wait_q) begin
          ext_q <= 1'b1;
          ewc_q <= '0;
        end
      end else if (!wait_q || at_max) begin
        ext_q <= 1'b0;
      end else begin
        ewc_q <= ewc_q + 1'b1;
      end
      // set wins over clear
      if (strobe_i && ext_q && wait_q && at_max) timeout_o <= 1'b1;
      else if (clr_i)                            timeout_o <= 1'b0;
    end
  end

  assign last_o = strobe_i && (ext_q ? (!wait_q || at_max)
                                     : (cnt_zero_i && !(en_i && wait_q)));
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int AW      = 14,
  parameter int BW      = 2,
  parameter int DW      = 16,
  parameter int NCS     = 4,
  parameter int SETUP_W = 4,
  parameter int STRB_W  = 6,
  parameter int HOLD_W  = 3,
  parameter int TA_W    = 2,
  parameter int MW_W    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [$clog2(NCS)-1:0] req_cs_i,
  input  logic [AW-1:0]          req_addr_i,
  input  logic [BW-1:0]          req_ba_i,
  input  logic [DW-1:0]          req_wdata_i,
  input  logic [TA_W-1:0]        cfg_turn_i,
  input  logic [SETUP_W-1:0]     cfg_rd_setup_i,
  input  logic [STRB_W-1:0]      cfg_rd_strobe_i,
  input  logic [HOLD_W-1:0]      cfg_rd_hold_i,
  input  logic [SETUP_W-1:0]     cfg_wr_setup_i,
  input  logic [STRB_W-1:0]      cfg_wr_strobe_i,
  input  logic [HOLD_W-1:0]      cfg_wr_hold_i,
  input  logic                   cfg_sel_strobe_i,
  input  logic                   cfg_wait_en_i,
  input  logic                   cfg_wait_pol_i,
  input  logic [MW_W-1:0]        cfg_wait_max_i,
  input  logic                   err_clr_i,
  output logic                   err_timeout_o,
  output logic [DW-1:0]          rd_data_o,
  output logic                   rd_valid_o,
  output logic [NCS-1:0]         mem_cs_no,
  output logic [AW-1:0]          mem_addr_o,
  output logic [BW-1:0]          mem_ba_o,
  output logic [DW-1:0]          mem_dq_o,
  input  logic [DW-1:0]          mem_dq_i,
  output logic                   mem_dq_oe_o,
  output logic                   mem_oe_no,
  output logic                   mem_we_no,
  input  logic                   mem_wait_i
);
  localparam int CSW   = $clog2(NCS);
  localparam int CNT_A = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CNT_B = (CNT_A > STRB_W) ? CNT_A : STRB_W;
  localparam int CNT_W = (CNT_B > TA_W) ? CNT_B : TA_W;

  phase_e           phase_q, phase_d;
  logic             wr_q;
  logic [CSW-1:0]   cs_idx_q;
  logic [AW-1:0]    addr_q;
  logic [BW-1:0]    ba_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;
  logic             strobe_last;
  logic             accept;
  logic             in_strobe, busy, cs_act;
  logic [CNT_W-1:0] setup_len;

  assign in_strobe   = (phase_q == PH_STROBE);
  assign busy        = (phase_q == PH_SETUP) || in_strobe || (phase_q == PH_HOLD);
  assign req_ready_o = (phase_q == PH_IDLE) || ((phase_q == PH_TURN) && cnt_zero);
  assign accept      = req_valid_i && req_ready_o;
  assign setup_len   = req_write_i ? CNT_W'(cfg_wr_setup_i) : CNT_W'(cfg_rd_setup_i);

  xmem_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (cnt_zero)
  );

  xmem_wait_unit #(.MW_W(MW_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_pin_i (mem_wait_i),
    .pol_i      (cfg_wait_pol_i),
    .en_i       (cfg_wait_en_i),
    .max_i      (cfg_wait_max_i),
    .strobe_i   (in_strobe),
    .cnt_zero_i (cnt_zero),
    .clr_i      (err_clr_i),
    .last_o     (strobe_last),
    .timeout_o  (err_timeout_o)
  );

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_SETUP; load = 1'b1; load_val = setup_len;
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d  = PH_STROBE; load = 1'b1;
        load_val = wr_q ? CNT_W'(cfg_wr_strobe_i) : CNT_W'(cfg_rd_strobe_i);
      end
      PH_STROBE: if (strobe_last) begin
        phase_d  = PH_HOLD; load = 1'b1;
        load_val = wr_q ? CNT_W'(cfg_wr_hold_i) : CNT_W'(cfg_rd_hold_i);
      end
      PH_HOLD: if (cnt_zero) begin
        phase_d = PH_TURN; load = 1'b1; load_val = CNT_W'(cfg_turn_i);
      end
      PH_TURN: if (cnt_zero) begin
        if (accept) begin
          phase_d = PH_SETUP; load = 1'b1; load_val = setup_len;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      wr_q     <= 1'b0;
      cs_idx_q <= '0;
      addr_q   <= '0;
      ba_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        wr_q     <= req_write_i;
        cs_idx_q <= req_cs_i;
        addr_q   <= req_addr_i;
        ba_q     <= req_ba_i;
        wdata_q  <= req_wdata_i;
      end
      rvalid_q <= strobe_last && !wr_q;
      if (strobe_last && !wr_q) rdata_q <= mem_dq_i;
    end
  end

  assign cs_act = cfg_sel_strobe_i ? in_strobe : busy;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign mem_cs_no[g] = !(cs_act && (cs_idx_q == CSW'(g)));
  end

  assign mem_addr_o  = addr_q;
  assign mem_ba_o    = ba_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = busy && wr_q;
  assign mem_oe_no   = !(in_strobe && !wr_q);
  assign mem_we_no   = !(in_strobe && wr_q);
  assign rd_data_o   = rdata_q;
  assign rd_valid_o  = rvalid_q;
endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
  parameter int AW  = 14,
  parameter int NCS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          err_clr_i,
  input logic          err_timeout_o,
  input logic          rd_valid_o,
  input logic [NCS-1:0] mem_cs_no,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o,
  input logic          mem_oe_no,
  input logic          mem_we_no
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no)); // R4
  AST_STROBE_HAS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> (mem_cs_no != '1)); // R4
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && $past(!mem_oe_no)) |-> $stable(mem_addr_o)); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R7
  AST_RVALID_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (mem_oe_no && $past(!mem_oe_no))); // R7
  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_timeout_o && !err_clr_i) |=> err_timeout_o); // R6
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_oe_no && mem_we_no && !mem_dq_oe_o)); // R8
endmodule

bind xmem_ctrl xmem_ctrl_chk #(.AW(AW), .NCS(NCS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .err_clr_i     (err_clr_i),
  .err_timeout_o (err_timeout_o),
  .rd_valid_o    (rd_valid_o),
  .mem_cs_no     (mem_cs_no),
  .mem_addr_o    (mem_addr_o),
  .mem_dq_oe_o   (mem_dq_oe_o),
  .mem_oe_no     (mem_oe_no),
  .mem_we_no     (mem_we_no)
);

// File: tb/xmem_ctrl_bench.sv
module xmem_ctrl_bench;
  typedef struct packed {
    logic        wr;
    logic [1:0]  cs;
    logic [13:0] addr;
    logic [1:0]  ba;
    logic [15:0] data;
    logic [4:0]  s;
    logic [6:0]  t;
    logic [3:0]  h;
    logic [2:0]  ta;
    logic        sel;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 14'h0123, 2'd1, 16'hA55A, 5'd1,  7'd1,  4'd1, 3'd1, 1'b0},
    '{1'b1, 2'd1, 14'h3FFF, 2'd3, 16'h1234, 5'd2,  7'd3,  4'd2, 3'd2, 1'b0},
    '{1'b0, 2'd2, 14'h2AAA, 2'd2, 16'hBEEF, 5'd16, 7'd64, 4'd8, 3'd4, 1'b0},
    '{1'b1, 2'd3, 14'h0001, 2'd0, 16'hFFFF, 5'd16, 7'd64, 4'd8, 3'd4, 1'b1},
    '{1'b0, 2'd3, 14'h1555, 2'd0, 16'h0F0F, 5'd3,  7'd2,  4'd4, 3'd3, 1'b1},
    '{1'b1, 2'd0, 14'h0000, 2'd0, 16'h0000, 5'd1,  7'd1,  4'd1, 3'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_cs = '0;
  logic [13:0] req_addr = '0;
  logic [1:0] req_ba = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] cfg_turn = '0;
  logic [3:0] cfg_rs = '0, cfg_ws = '0;
  logic [5:0] cfg_rst = '0, cfg_wst = '0;
  logic [2:0] cfg_rh = '0, cfg_wh = '0;
  logic cfg_sel = 1'b0, cfg_wen = 1'b0, cfg_wpol = 1'b1;
  logic [7:0] cfg_wmax = '0;
  logic err_clr = 1'b0;
  logic [15:0] mem_din = '0;
  logic mem_wait = 1'b0;
  logic req_ready, err_timeout, rd_valid, dq_oe, oe_n, we_n;
  logic [15:0] rd_data, dq_o;
  logic [3:0] cs_n;
  logic [13:0] addr_o;
  logic [1:0] ba_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xmem_ctrl u_xmem_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .req_ba_i(req_ba), .req_wdata_i(req_wdata),
    .cfg_turn_i(cfg_turn), .cfg_rd_setup_i(cfg_rs), .cfg_rd_strobe_i(cfg_rst),
    .cfg_rd_hold_i(cfg_rh), .cfg_wr_setup_i(cfg_ws), .cfg_wr_strobe_i(cfg_wst),
    .cfg_wr_hold_i(cfg_wh), .cfg_sel_strobe_i(cfg_sel), .cfg_wait_en_i(cfg_wen),
    .cfg_wait_pol_i(cfg_wpol), .cfg_wait_max_i(cfg_wmax), .err_clr_i(err_clr),
    .err_timeout_o(err_timeout), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .mem_cs_no(cs_n), .mem_addr_o(addr_o), .mem_ba_o(ba_o), .mem_dq_o(dq_o),
    .mem_dq_i(mem_din), .mem_dq_oe_o(dq_oe), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_wait_i(mem_wait)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-access mismatch bookkeeping: 0 strobe, 1 cs, 2 addr/data, 3 ready, 4 rdata
  bit          bad [5];
  logic [31:0] a_v [5];
  logic [31:0] e_v [5];

  task automatic note(input int c, input logic [31:0] a, input logic [31:0] e);
    if (a !== e && !bad[c]) begin
      bad[c] = 1'b1; a_v[c] = a; e_v[c] = e;
    end
  endtask

  task automatic run(input vec_t v, input bit ext, input bit pol,
                     input int w_lo, input int w_hi, input int extra,
                     input logic [7:0] wmax);
    int S, T, H, TA, st_end, h_end, total;
    S = int'(v.s); T = int'(v.t); H = int'(v.h); TA = int'(v.ta);
    st_end = S + T + extra; h_end = st_end + H; total = h_end + TA;
    for (int c = 0; c < 5; c++) begin bad[c] = 1'b0; a_v[c] = '0; e_v[c] = '0; end
    @(negedge clk);
    if (v.wr) begin
      cfg_ws = 4'(S - 1); cfg_wst = 6'(T - 1); cfg_wh = 3'(H - 1);
      cfg_rs = ~cfg_ws;   cfg_rst = ~cfg_wst;  cfg_rh = ~cfg_wh;
    end else begin
      cfg_rs = 4'(S - 1); cfg_rst = 6'(T - 1); cfg_rh = 3'(H - 1);
      cfg_ws = ~cfg_rs;   cfg_wst = ~cfg_rst;  cfg_wh = ~cfg_rh;
    end
    cfg_turn = 2'(TA - 1); cfg_sel = v.sel; cfg_wen = ext; cfg_wpol = pol; cfg_wmax = wmax;
    req_write = v.wr; req_cs = v.cs; req_addr = v.addr; req_ba = v.ba;
    req_wdata = v.data; mem_din = v.data;
    mem_wait = (w_lo <= 0 && 0 <= w_hi) ? pol : !pol;
    req_valid = 1'b1;
    note(3, {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= total; k++) begin
      bit stb, busy, csa;
      logic [3:0] ecs;
      mem_wait = (w_lo <= k && k <= w_hi) ? pol : !pol;
      stb  = (k > S) && (k <= st_end);
      busy = (k <= h_end);
      csa  = v.sel ? stb : busy;
      ecs  = csa ? ~(4'b0001 << v.cs) : 4'hF;
      note(0, {30'd0, oe_n, we_n}, {30'd0, !(stb && !v.wr), !(stb && v.wr)});
      note(1, {28'd0, cs_n}, {28'd0, ecs});
      note(2, {31'd0, dq_oe}, {31'd0, v.wr && busy});
      if (busy) note(2, {16'd0, addr_o, ba_o}, {16'd0, v.addr, v.ba});
      if (busy && v.wr) note(2, {16'd0, dq_o}, {16'd0, v.data});
      note(3, {31'd0, req_ready}, {31'd0, k == total});
      note(4, {31'd0, rd_valid}, {31'd0, !v.wr && (k == st_end + 1)});
      if (!v.wr && k == st_end + 1) note(4, {16'd0, rd_data}, {16'd0, v.data});
      if (k < total) @(negedge clk);
    end
    mem_wait = !pol;
    chk(!bad[0], v.wr ? "R2" : "R1", "strobe shape", a_v[0], e_v[0]);
    chk(!bad[1], "R4", "chip select", a_v[1], e_v[1]);
    chk(!bad[2], "R3", "address/data drive", a_v[2], e_v[2]);
    chk(!bad[3], "R8", "ready/turnaround", a_v[3], e_v[3]);
    if (!v.wr) chk(!bad[4], "R7", "read capture", a_v[4], e_v[4]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t wv;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cs_n === 4'hF && oe_n === 1'b1 && we_n === 1'b1, "R9", "strobes idle",
        {24'd0, cs_n, 2'd0, oe_n, we_n}, {24'd0, 4'hF, 2'd0, 2'b11});
    chk(dq_oe === 1'b0 && rd_valid === 1'b0 && err_timeout === 1'b0 && req_ready === 1'b1,
        "R9", "flags idle", {28'd0, dq_oe, rd_valid, err_timeout, req_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0, 1'b1, -1, -1, 0, 8'd0);

    wv = '{1'b0, 2'd1, 14'h0777, 2'd1, 16'hC0DE, 5'd2, 7'd8, 4'd2, 3'd1, 1'b0};
    // R5 extension, active-high wait, released after three extra cycles
    run(wv, 1'b1, 1'b1, 6, 12, 4, 8'd255);
    chk(err_timeout === 1'b0, "R5", "no timeout on release", {31'd0, err_timeout}, 32'd0);
    // R5 same waveform on a write with active-low wait
    wv.wr = 1'b1; wv.data = 16'h5A5A;
    run(wv, 1'b1, 1'b0, 6, 12, 4, 8'd255);
    // R5 wait ignored when extension disabled
    wv.wr = 1'b0;
    run(wv, 1'b0, 1'b1, 0, 1000, 0, 8'd0);
    // R5 wait gone before last nominal strobe cycle: no extension
    run(wv, 1'b1, 1'b1, 2, 7, 0, 8'd0);
    chk(err_timeout === 1'b0, "R5", "no timeout without extension", {31'd0, err_timeout}, 32'd0);
    // R6 timeout after max+1 extra cycles
    run(wv, 1'b1, 1'b1, 0, 1000, 3, 8'd2);
    chk(err_timeout === 1'b1, "R6", "timeout set", {31'd0, err_timeout}, 32'd1);
    run(VECS[0], 1'b0, 1'b1, -1, -1, 0, 8'd0);
    chk(err_timeout === 1'b1, "R6", "timeout sticky", {31'd0, err_timeout}, 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err_timeout === 1'b0, "R6", "timeout cleared", {31'd0, err_timeout}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule